// File: doc/BRIEF.md
# Multi-lane SPI frame shifter

This block is the host side of a serial peripheral link. It moves one frame of up to eight bits per request. Each request picks its own shape: the number of data lanes (one, two or four), the bit order, the frame length, the level at which the serial clock rests, and the clock edge on which data is captured. The serial clock comes from the system clock through a divider. Each half period of the serial clock lasts `clk_div + 1` system clock cycles, so SCK runs at sysclk / (2·(clk_div+1)).

Requests come in over a valid/ready handshake. `req_ready` is high only while the engine is idle, so a requester that holds `req_valid` high simply waits. All request fields must stay stable while `req_valid` is high and `req_ready` is low. The result is a one-cycle `rsp_valid` pulse that carries `rsp_data`. The response side has no back-pressure: the consumer must take the byte in that cycle. Chip select goes low for exactly one frame per request.

In single-lane mode, lane 0 always transmits and lane 1 always receives. In dual or quad mode, a per-request direction bit makes all active lanes either drive or listen. The frame length must then be a whole multiple of the lane count. `clk_div` must be at least 1 and is captured when a request is accepted.

Top module: `spi_lane_shifter`

## Requirements
- R1: A request is accepted on a clock where `req_valid` and `req_ready` are both high. `req_ready` is low from the next cycle until the frame ends, and `cs_n` is low over the same span. The end is marked by `rsp_valid` high for exactly one cycle, on the same cycle that `cs_n` returns high.
- R2: `sck` rests at the requested idle level (`req_cpol` 0 = low, 1 = high; low after reset) whenever `cs_n` is high. During a frame it makes exactly 2·len/lanes transitions and ends back at its idle level.
- R3: The first `sck` transition comes `clk_div+1` cycles after `cs_n` falls. Successive transitions are `clk_div+1` cycles apart. `cs_n` rises `clk_div+1` cycles after the last transition.
- R4: Lane mode code 0 is single lane. In this mode `dq_oe` is 4'b0001 while `cs_n` is low, transmit bits leave on `dq_out[0]`, and receive bits are taken from `dq_in[1]`, one bit per SCK cycle.
- R5: `req_lsb_first` 0 sends and receives the most significant of the `req_len` bits first. Value 1 sends and receives bit 0 first.
- R6: With `req_cpha` 0, data is captured on the leading edge (leaving the idle level), and the first outgoing bits are on the lines before that edge. With `req_cpha` 1, outgoing data changes on leading edges and is captured on trailing edges.
- R7: Lane mode code 1 (dual) and code 2 (quad) with `req_dir_tx` 1 drive `dq_out[1:0]` or `dq_out[3:0]`, with `dq_oe` 4'b0011 or 4'b1111, carrying 2 or 4 bits per SCK cycle. The higher-numbered lane carries the earlier bit of the stream. The response byte is then zero.
- R8: Dual or quad with `req_dir_tx` 0 keeps `dq_oe` at 4'b0000 and captures 2 or 4 bits per SCK cycle from `dq_in`, using the same lane order as R7. `dq_oe` is 4'b0000 whenever `cs_n` is high.
- R9: For frames shorter than eight bits, the received bits are right-justified in `rsp_data` and the unused upper bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | DIV_W | Half-period length minus one, in system cycles (at least 1) |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_data | input | FRAME_W | Bits to transmit, right-justified |
| req_len | input | LEN_W | Frame length in bits, 1 to FRAME_W |
| req_lanes | input | 2 | Lane mode: 0 single, 1 dual, 2 quad |
| req_lsb_first | input | 1 | Bit order: 0 most significant first, 1 least significant first |
| req_cpol | input | 1 | SCK idle level |
| req_cpha | input | 1 | 0 capture on leading edge, 1 capture on trailing edge |
| req_dir_tx | input | 1 | Dual/quad direction: 1 drive lanes, 0 listen |
| rsp_valid | output | 1 | One-cycle frame-done pulse |
| rsp_data | output | FRAME_W | Received bits, right-justified |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| dq_out | output | 4 | Data lane outputs |
| dq_oe | output | 4 | Data lane output enables |
| dq_in | input | 4 | Data lane inputs |

## Verification
The embedded properties watch the framing on every cycle. `req_ready` stays low under an active chip select, the done pulse is one cycle long and coincides with chip select release, `sck` holds still while deselected, no lane is enabled when deselected, divider ticks never land on adjacent cycles, and capture and launch never happen on the same edge. The actual bit stream can only be shown by the scenarios. These cover lane order, bit order, clock phase and polarity, right-justification of short frames, the edge count and the exact setup and hold spacing around chip select. The bench checks them against a peripheral model that shifts its own pattern and records what it sees on the lines.

// File: rtl/spi_lane_pkg.sv
`timescale 1ns/1ps
package spi_lane_pkg;

  typedef enum logic [1:0] {
    LANE_X1 = 2'd0,
    LANE_X2 = 2'd1,
    LANE_X4 = 2'd2
  } lane_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_HOLD  = 2'd2
  } eng_state_e;

  // log2 of the lane count; the reserved code falls back to one lane
  function automatic logic [1:0] lane_log2(input lane_mode_e m);
    case (m)
      LANE_X2: return 2'd1;
      LANE_X4: return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [3:0] lane_mask(input lane_mode_e m);
    case (m)
      LANE_X2: return 4'b0011;
      LANE_X4: return 4'b1111;
      default: return 4'b0001;
    endcase
  endfunction

endpackage

// File: rtl/spi_edge_timer.sv
`timescale 1ns/1ps
module spi_edge_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == half_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3
  half_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/spi_lane_shift.sv
`timescale 1ns/1ps
module spi_lane_shift
  import spi_lane_pkg::*;
#(
  parameter int FRAME_W = 8,
  parameter int LEN_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               load_launch,
  input  logic [FRAME_W-1:0] load_data,
  input  logic [LEN_W-1:0]   load_len,
  input  lane_mode_e         load_mode,
  input  logic               load_lsb,
  input  logic               launch,
  input  logic               sample,
  input  logic [3:0]         dq_in,
  output logic [3:0]         dq_out,
  output logic [FRAME_W-1:0] result
);

  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(FRAME_W);

  logic [FRAME_W-1:0] tx_q, rx_q, tx_init, rev_in, rev_rx, in_chunk;
  logic [3:0]         dq_q, step_now, step_new;
  lane_mode_e         mode_q;
  logic               lsb_q;
  logic [LEN_W-1:0]   len_q;

  // first bits of a left-aligned stream, earliest bit on the highest lane
  function automatic logic [3:0] head(input logic [FRAME_W-1:0] v, input lane_mode_e m);
    case (lane_log2(m))
      2'd1:    return {2'b00, v[FRAME_W-1 -: 2]};
      2'd2:    return v[FRAME_W-1 -: 4];
      default: return {3'b000, v[FRAME_W-1]};
    endcase
  endfunction

  for (genvar i = 0; i < FRAME_W; i++) begin : g_rev
    assign rev_in[i] = load_data[FRAME_W-1-i];
    assign rev_rx[i] = rx_q[FRAME_W-1-i];
  end

  always_comb begin
    tx_init  = load_lsb ? rev_in : (load_data << (FULL_LEN - load_len));
    step_now = 4'd1 << lane_log2(mode_q);
    step_new = 4'd1 << lane_log2(load_mode);
    case (lane_log2(mode_q))
      2'd1:    in_chunk = FRAME_W'(dq_in[1:0]);
      2'd2:    in_chunk = FRAME_W'(dq_in);
      default: in_chunk = FRAME_W'(dq_in[1]);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      dq_q   <= '0;
      mode_q <= LANE_X1;
      lsb_q  <= 1'b0;
      len_q  <= '0;
    end else if (load) begin
      mode_q <= load_mode;
      lsb_q  <= load_lsb;
      len_q  <= load_len;
      rx_q   <= '0;
      if (load_launch) begin
        dq_q <= head(tx_init, load_mode);
        tx_q <= tx_init << step_new;
      end else begin
        dq_q <= '0;
        tx_q <= tx_init;
      end
    end else begin
      if (launch) begin
        dq_q <= head(tx_q, mode_q);
        tx_q <= tx_q << step_now;
      end
      if (sample) begin
        rx_q <= (rx_q << step_now) | in_chunk;
      end
    end
  end

  assign dq_out = dq_q;
  assign result = lsb_q ? (rev_rx >> (FULL_LEN - len_q)) : rx_q;

  // R6
  lane_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(launch && sample));

endmodule

// File: rtl/spi_lane_shifter.sv
`timescale 1ns/1ps
module spi_lane_shifter
  import spi_lane_pkg::*;
#(
  parameter int FRAME_W = 8,
  parameter int DIV_W   = 8,
  localparam int LEN_W  = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIV_W-1:0]   clk_div,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [FRAME_W-1:0] req_data,
  input  logic [LEN_W-1:0]   req_len,
  input  logic [1:0]         req_lanes,
  input  logic               req_lsb_first,
  input  logic               req_cpol,
  input  logic               req_cpha,
  input  logic               req_dir_tx,
  output logic               rsp_valid,
  output logic [FRAME_W-1:0] rsp_data,
  output logic               sck,
  output logic               cs_n,
  output logic [3:0]         dq_out,
  output logic [3:0]         dq_oe,
  input  logic [3:0]         dq_in
);

  localparam int EDGE_W = $clog2(2 * FRAME_W + 1);

  eng_state_e         state_q;
  lane_mode_e         req_mode, mode_q;
  logic [DIV_W-1:0]   div_q;
  logic [EDGE_W-1:0]  edge_q, last_edge_q;
  logic [LEN_W-1:0]   req_cycles;
  logic               cpha_q, dir_q, sck_q, cs_n_q, rsp_q;
  logic               accept, tick, shifting, leading, capture_edge;
  logic               single_q, rx_active, dp_launch, dp_sample;

  assign req_mode   = lane_mode_e'(req_lanes);
  assign req_ready  = (state_q == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign req_cycles = req_len >> lane_log2(req_mode);
  assign shifting   = (state_q == ST_SHIFT) && tick;
  assign leading    = !edge_q[0];
  assign capture_edge = leading ^ cpha_q;
  assign single_q   = (lane_log2(mode_q) == 2'd0);
  assign rx_active  = single_q || !dir_q;
  assign dp_sample  = shifting && capture_edge && rx_active;
  assign dp_launch  = shifting && !capture_edge;

  spi_edge_timer #(.DIV_W(DIV_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (state_q != ST_IDLE),
    .half_div (div_q),
    .tick     (tick)
  );

  spi_lane_shift #(.FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (accept),
    .load_launch (!req_cpha),
    .load_data   (req_data),
    .load_len    (req_len),
    .load_mode   (req_mode),
    .load_lsb    (req_lsb_first),
    .launch      (dp_launch),
    .sample      (dp_sample),
    .dq_in       (dq_in),
    .dq_out      (dq_out),
    .result      (rsp_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      mode_q      <= LANE_X1;
      div_q       <= '0;
      edge_q      <= '0;
      last_edge_q <= '0;
      cpha_q      <= 1'b0;
      dir_q       <= 1'b0;
      sck_q       <= 1'b0;
      cs_n_q      <= 1'b1;
      rsp_q       <= 1'b0;
    end else begin
      rsp_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            state_q     <= ST_SHIFT;
            mode_q      <= req_mode;
            div_q       <= clk_div;
            cpha_q      <= req_cpha;
            dir_q       <= req_dir_tx;
            sck_q       <= req_cpol;
            cs_n_q      <= 1'b0;
            edge_q      <= '0;
            last_edge_q <= EDGE_W'({req_cycles, 1'b0}) - EDGE_W'(1);
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            sck_q  <= ~sck_q;
            edge_q <= edge_q + 1'b1;
            if (edge_q == last_edge_q) state_q <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (tick) begin
            cs_n_q  <= 1'b1;
            rsp_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    if (cs_n_q)        dq_oe = 4'b0000;
    else if (single_q) dq_oe = 4'b0001;
    else if (dir_q)    dq_oe = lane_mask(mode_q);
    else               dq_oe = 4'b0000;
  end

  assign sck       = sck_q;
  assign cs_n      = cs_n_q;
  assign rsp_valid = rsp_q;

  // R1
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !req_ready);

  // R1
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R1
  rsp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> cs_n);

  // R2
  idle_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_n) && cs_n) |-> $stable(sck));

  // R8
  idle_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (dq_oe == 4'b0000));

endmodule

// File: tb/spi_lane_shifter_test.sv
`timescale 1ns/1ps
module spi_lane_shifter_test;

  localparam int FW = 8;
  localparam int DW = 8;
  localparam int LW = $clog2(FW + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] clk_div = DW'(1);
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [FW-1:0] req_data = '0;
  logic [LW-1:0] req_len = '0;
  logic [1:0]    req_lanes = '0;
  logic          req_lsb_first = 1'b0, req_cpol = 1'b0, req_cpha = 1'b0, req_dir_tx = 1'b0;
  logic          rsp_valid;
  logic [FW-1:0] rsp_data;
  logic          sck, cs_n;
  logic [3:0]    dq_out, dq_oe;
  logic [3:0]    dq_in = 4'b0000;

  always #2 clk = ~clk;

  spi_lane_shifter #(.FRAME_W(FW), .DIV_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div),
    .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data),
    .req_len(req_len), .req_lanes(req_lanes), .req_lsb_first(req_lsb_first),
    .req_cpol(req_cpol), .req_cpha(req_cpha), .req_dir_tx(req_dir_tx),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .sck(sck), .cs_n(cs_n),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct {
    logic [7:0] rx;
    logic [7:0] tx;
    bit         tx_chk;
    int         edges;
    bit         cpol;
    string      tag;
  } sb_item_t;

  sb_item_t sb[$];

  // current peripheral-model setup
  int         cur_k = 1, cur_len = 8, cur_div = 1;
  bit         cur_lsb, cur_cpha, cur_dir;
  logic [7:0] dev_val;

  function automatic bit sbit(input logic [7:0] v, input int len, input bit lsb, input int i);
    return lsb ? v[i] : v[len-1-i];
  endfunction

  // peripheral model state
  bit         prev_sck = 1'b0, prev_cs = 1'b1, prev_rsp = 1'b0;
  int         dev_edges, dev_sidx, cap_idx, since_start, since_edge;
  logic [7:0] cap_val;

  function automatic bit rx_role();
    return (cur_k == 1) || !cur_dir;
  endfunction

  task automatic dev_present();
    logic [3:0] v;
    v = 4'b0000;
    if (rx_role()) begin
      if (cur_k == 1) begin
        if (dev_sidx < cur_len) v[1] = sbit(dev_val, cur_len, cur_lsb, dev_sidx);
      end else begin
        for (int ln = 0; ln < cur_k; ln++)
          if (dev_sidx + cur_k - 1 - ln < cur_len)
            v[ln] = sbit(dev_val, cur_len, cur_lsb, dev_sidx + cur_k - 1 - ln);
      end
    end
    dq_in = v;
    dev_sidx += cur_k;
  endtask

  task automatic dev_capture();
    int idx;
    if ((cur_k == 1) || cur_dir) begin
      for (int ln = 0; ln < cur_k; ln++) begin
        idx = cap_idx + cur_k - 1 - ln;
        if (idx < cur_len) cap_val[cur_lsb ? idx : cur_len - 1 - idx] = dq_out[ln];
      end
    end
    cap_idx += cur_k;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      since_start++;
      since_edge++;
      if (prev_cs && !cs_n) begin
        dev_edges = 0; dev_sidx = 0; cap_idx = 0; since_start = 0; cap_val = 8'h00;
        chk(!req_ready, "R1 ready low while selected", req_ready, 0);
        if (!cur_cpha) dev_present();
      end else if (!cs_n && (sck != prev_sck)) begin
        if (dev_edges == 0) begin
          chk(since_start == cur_div + 1, "R3 select to first edge", since_start, cur_div + 1);
          chk(dq_oe == ((cur_k == 1) ? 4'b0001 : (cur_dir ? ((cur_k == 2) ? 4'b0011 : 4'b1111) : 4'b0000)),
              "R4 R7 R8 lane enables", dq_oe, 0);
        end else begin
          chk(since_edge == cur_div + 1, "R3 edge spacing", since_edge, cur_div + 1);
        end
        since_edge = 0;
        if (((dev_edges % 2) == 0) ^ cur_cpha) dev_capture();
        else dev_present();
        dev_edges++;
      end else if (!prev_cs && cs_n) begin
        chk(since_edge == cur_div + 1, "R3 last edge to release", since_edge, cur_div + 1);
      end
      prev_cs  = cs_n;
      prev_sck = sck;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_rsp) chk(!rsp_valid, "R1 done pulse one cycle", rsp_valid, 0);
      if (rsp_valid) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R1 unexpected done", 1, 0);
        end else begin
          sb_item_t it;
          it = sb.pop_front();
          chk(cs_n, "R1 release with done", cs_n, 1);
          chk(rsp_data == it.rx, {it.tag, " received byte"}, rsp_data, it.rx);
          if (it.tx_chk) chk(cap_val == it.tx, {it.tag, " transmitted bits"}, cap_val, it.tx);
          chk(dev_edges == it.edges, "R2 edge count", dev_edges, it.edges);
          chk(sck == it.cpol, "R2 idle level after frame", sck, it.cpol);
        end
      end
      prev_rsp = rsp_valid;
    end
  end

  task automatic send(input int k, input int len, input logic [7:0] data, input bit lsb,
                      input bit cpol, input bit cpha, input bit dir, input logic [7:0] dv,
                      input int dv_div, input string tag);
    sb_item_t it;
    logic [7:0] mask;
    mask = 8'((9'd1 << len) - 9'd1);
    cur_k = k; cur_len = len; cur_lsb = lsb; cur_cpha = cpha; cur_dir = dir;
    cur_div = dv_div; dev_val = dv;
    it.rx     = ((k == 1) || !dir) ? (dv & mask) : 8'h00;
    it.tx     = data & mask;
    it.tx_chk = (k == 1) || dir;
    it.edges  = 2 * len / k;
    it.cpol   = cpol;
    it.tag    = tag;
    sb.push_back(it);
    @(negedge clk);
    req_valid = 1'b1; req_data = data; req_len = LW'(len);
    req_lanes = (k == 1) ? 2'd0 : ((k == 2) ? 2'd1 : 2'd2);
    req_lsb_first = lsb; req_cpol = cpol; req_cpha = cpha; req_dir_tx = dir;
    clk_div = DW'(dv_div);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=done", wd);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1'b1, "R1 reset chip select", cs_n, 1);
    chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1 reset done", rsp_valid, 0);
    chk(sck == 1'b0, "R2 reset idle level", sck, 0);
    chk(dq_oe == 4'b0000, "R8 reset enables", dq_oe, 0);

    send(1, 8, 8'hA5, 0, 0, 0, 0, 8'h3C, 1, "R4 R5 R6");
    send(1, 8, 8'h96, 1, 1, 1, 0, 8'hC1, 2, "R4 R5 R6");
    send(1, 5, 8'h1B, 0, 0, 1, 0, 8'h15, 1, "R9 R5");
    send(1, 3, 8'h06, 1, 1, 0, 0, 8'h05, 3, "R9 R5");
    send(2, 8, 8'hD2, 0, 0, 0, 1, 8'h00, 1, "R7");
    send(2, 6, 8'h00, 1, 1, 1, 0, 8'h2D, 2, "R8 R9");
    send(4, 8, 8'h7E, 1, 0, 1, 1, 8'h00, 1, "R7 R5");
    send(4, 8, 8'h00, 0, 1, 0, 0, 8'hB4, 1, "R8");
    send(4, 4, 8'h00, 1, 0, 0, 0, 8'h09, 4, "R8 R9");
    send(1, 1, 8'h01, 0, 0, 0, 0, 8'h01, 1, "R9");

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule